// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block refills one cache line after a miss. A cache hands it the byte address that missed. The block then asks a word-serial memory port for every word of that line. It starts with the word the requester needs, goes on with the next higher word offset, wraps to offset zero of the same line, and stops at the word just below the requested one.

Each word that memory returns is stored in the line buffer at the offset it was requested for. When the requested word arrives, the requester gets a one-cycle early-restart pulse carrying that word, so it can resume before the line is complete. Once the last word has been written, the block raises a one-cycle done strobe. At the same time it marks the line valid and publishes the line's tag, which is the address bits above the line offset.

Only one refill runs at a time. New misses are refused until the current line is finished.

Top module: `line_refill_seq`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `line_valid`, `restart_pulse` and `fill_done` are 0, and `miss_ready` is 1.
- R2: The first memory request after a miss is accepted carries the requested word offset. With the defaults this is miss address bits [4:2]. The request keeps the miss's line address (bits above bit 4) and has zero byte bits [1:0].
- R3: Each further request raises the word offset by one modulo WORDS, so offset 7 is followed by offset 0. Exactly WORDS requests are issued per miss, and the last one is for the offset just below the requested one.
- R4: Memory responses come back in request order. Each response is written to the offset of its request, and word i of the line appears on `line_data[i*DATA_W +: DATA_W]`.
- R5: `restart_pulse` is high for exactly one cycle, the cycle after the first response is captured. In that cycle `restart_data` equals the requested word. It comes before `fill_done`.
- R6: `busy` rises the cycle after a miss is accepted and stays high until the done cycle. A miss presented while busy is ignored: it changes neither the requested line nor the word order.
- R7: `fill_done` is high for exactly one cycle, the cycle after the WORDS-th response is captured, and `busy` is 0 in that cycle.
- R8: While `fill_done` is high and afterwards, `line_valid` is 1 and `line_tag` equals the miss address bits above the line offset (bits [31:5] by default). `line_valid` drops to 0 when a new miss is accepted.
- R9: A request that is not accepted (`mem_req_ready` low) keeps `mem_req_valid` high with an unchanged address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss address is offered |
| miss_addr | input | ADDR_W | Byte address that missed |
| miss_ready | output | 1 | Block is idle and takes a miss |
| busy | output | 1 | A refill is in progress |
| mem_req_valid | output | 1 | Word request to memory is pending |
| mem_req_addr | output | ADDR_W | Byte address of the requested word |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | A response word is present |
| mem_rsp_data | input | DATA_W | Response word, in request order |
| restart_pulse | output | 1 | One-cycle early-restart strobe |
| restart_data | output | DATA_W | Requested word, valid with the strobe |
| fill_done | output | 1 | One-cycle line-complete strobe |
| line_valid | output | 1 | Installed line is valid |
| line_tag | output | ADDR_W-LINE_LSB | Tag of the installed line |
| line_data | output | WORDS*DATA_W | Line buffer, word 0 at the low end |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 32-bit words and 8-word lines. Eight words make the modulo-8 wrap visible from every starting offset.

The starting offsets tested are 0, 1, 3, 5, 6 and 7. Offset 0 gives a fill with no wrap, and offset 7 gives a wrap right after the first word. An all-ones tag shows that the tag is carried intact.

A second memory pattern withholds ready and responses in a pseudo-random way. This exercises request stalls and a late restart. Refills run back to back from the done cycle, and decoy misses are offered while the block is busy.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   typedef enum logic [0:0] {
      LRS_IDLE = 1'b0,
      LRS_FILL = 1'b1
   } lrs_state_e;
endpackage

// File: rtl/lrs_wrap_ctr.sv
module lrs_wrap_ctr #(
   parameter int OFS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OFS_W-1:0] load_ofs,
   input  logic             step,
   output logic [OFS_W-1:0] ofs,
   output logic [OFS_W:0]   cnt
);
   // Offset wraps naturally at 2**OFS_W; cnt tracks steps since load.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs <= '0;
         cnt <= '0;
      end else if (load) begin
         ofs <= load_ofs;
         cnt <= '0;
      end else if (step) begin
         ofs <= ofs + 1'b1;
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/lrs_line_buf.sv
module lrs_line_buf #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   localparam int OFS_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [OFS_W-1:0]        wr_ofs,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [WORDS*DATA_W-1:0] line_q
);
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            line_q[g*DATA_W +: DATA_W] <= '0;
         end else if (wr_en && (wr_ofs == OFS_W'(g))) begin
            line_q[g*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/line_refill_seq.sv
module line_refill_seq #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   localparam int BYTE_W   = $clog2(DATA_W / 8),
   localparam int OFS_W    = $clog2(WORDS),
   localparam int LINE_LSB = BYTE_W + OFS_W,
   localparam int TAG_W    = ADDR_W - LINE_LSB
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    miss_valid,
   input  logic [ADDR_W-1:0]       miss_addr,
   output logic                    miss_ready,
   output logic                    busy,
   output logic                    mem_req_valid,
   output logic [ADDR_W-1:0]       mem_req_addr,
   input  logic                    mem_req_ready,
   input  logic                    mem_rsp_valid,
   input  logic [DATA_W-1:0]       mem_rsp_data,
   output logic                    restart_pulse,
   output logic [DATA_W-1:0]       restart_data,
   output logic                    fill_done,
   output logic                    line_valid,
   output logic [TAG_W-1:0]        line_tag,
   output logic [WORDS*DATA_W-1:0] line_data
);
   import lrs_pkg::*;

   localparam logic [OFS_W:0] CNT_FULL = (OFS_W + 1)'(WORDS);
   localparam logic [OFS_W:0] CNT_LAST = (OFS_W + 1)'(WORDS - 1);

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0 || ((DATA_W / 8) & (DATA_W / 8 - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be 8 times a power of two");
   end
   if (ADDR_W <= LINE_LSB) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   lrs_state_e           state_q;
   logic [TAG_W-1:0]     base_q;
   logic [OFS_W-1:0]     iss_ofs, rcv_ofs;
   logic [OFS_W:0]       iss_cnt, rcv_cnt;
   logic                 accept, req_fire, rsp_take, rsp_first, rsp_last;
   logic [OFS_W-1:0]     crit_ofs;

   assign crit_ofs   = miss_addr[LINE_LSB-1:BYTE_W];
   assign miss_ready = (state_q == LRS_IDLE);
   assign busy       = (state_q == LRS_FILL);
   assign accept     = miss_valid && miss_ready;

   assign mem_req_valid = busy && (iss_cnt != CNT_FULL);
   assign req_fire      = mem_req_valid && mem_req_ready;
   assign rsp_take      = busy && mem_rsp_valid && (rcv_cnt != CNT_FULL);
   assign rsp_first     = rsp_take && (rcv_cnt == '0);
   assign rsp_last      = rsp_take && (rcv_cnt == CNT_LAST);

   if (BYTE_W > 0) begin : g_byte_pad
      assign mem_req_addr = {base_q, iss_ofs, {BYTE_W{1'b0}}};
   end else begin : g_no_pad
      assign mem_req_addr = {base_q, iss_ofs};
   end

   lrs_wrap_ctr #(.OFS_W(OFS_W)) u_iss_ctr (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_ofs(crit_ofs),
      .step(req_fire), .ofs(iss_ofs), .cnt(iss_cnt)
   );

   lrs_wrap_ctr #(.OFS_W(OFS_W)) u_rcv_ctr (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_ofs(crit_ofs),
      .step(rsp_take), .ofs(rcv_ofs), .cnt(rcv_cnt)
   );

   lrs_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(rsp_take), .wr_ofs(rcv_ofs),
      .wr_data(mem_rsp_data), .line_q(line_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= LRS_IDLE;
         base_q        <= '0;
         restart_pulse <= 1'b0;
         restart_data  <= '0;
         fill_done     <= 1'b0;
         line_valid    <= 1'b0;
         line_tag      <= '0;
      end else begin
         restart_pulse <= rsp_first;
         fill_done     <= rsp_last;
         if (rsp_first) restart_data <= mem_rsp_data;
         if (accept) begin
            state_q    <= LRS_FILL;
            base_q     <= miss_addr[ADDR_W-1:LINE_LSB];
            line_valid <= 1'b0;
         end else if (rsp_last) begin
            state_q    <= LRS_IDLE;
            line_valid <= 1'b1;
            line_tag   <= base_q;
         end
      end
   end
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   localparam int BYTE_W   = $clog2(DATA_W / 8),
   localparam int OFS_W    = $clog2(WORDS),
   localparam int LINE_LSB = BYTE_W + OFS_W,
   localparam int TAG_W    = ADDR_W - LINE_LSB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_valid,
   input logic [ADDR_W-1:0] miss_addr,
   input logic              miss_ready,
   input logic              busy,
   input logic              mem_req_valid,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_req_ready,
   input logic              restart_pulse,
   input logic              fill_done,
   input logic              line_valid,
   input logic [TAG_W-1:0]  line_tag
);
   logic [OFS_W-1:0] exp_first_ofs, last_ofs, next_ofs, req_ofs;
   logic [TAG_W-1:0] exp_base, req_base;
   logic             first_pend;

   assign req_ofs  = mem_req_addr[LINE_LSB-1:BYTE_W];
   assign req_base = mem_req_addr[ADDR_W-1:LINE_LSB];
   assign next_ofs = last_ofs + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_first_ofs <= '0;
         exp_base      <= '0;
         last_ofs      <= '0;
         first_pend    <= 1'b0;
      end else begin
         if (miss_valid && miss_ready) begin
            exp_first_ofs <= miss_addr[LINE_LSB-1:BYTE_W];
            exp_base      <= miss_addr[ADDR_W-1:LINE_LSB];
            first_pend    <= 1'b1;
         end else if (mem_req_valid && mem_req_ready) begin
            first_pend <= 1'b0;
         end
         if (mem_req_valid && mem_req_ready) last_ofs <= req_ofs;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);
   a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && first_pend) |-> (req_ofs == exp_first_ofs));
   a_r3_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !first_pend) |-> (req_ofs == next_ofs));
   a_r5_restart_once: assert property (@(posedge clk) disable iff (!rst_n)
      restart_pulse |=> !restart_pulse);
   a_r6_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (req_base == exp_base));
   a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> busy);
   a_r7_done_once: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !fill_done);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> !busy);
   a_r8_done_tag: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (line_valid && line_tag == exp_base));
   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind line_refill_seq lrs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) chk_i (
   .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
   .miss_ready(miss_ready), .busy(busy), .mem_req_valid(mem_req_valid),
   .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
   .restart_pulse(restart_pulse), .fill_done(fill_done),
   .line_valid(line_valid), .line_tag(line_tag)
);

// File: tb/line_refill_seq_tb.sv
module line_refill_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int WORDS  = 8;
   localparam int TAG_W  = 27;
   localparam int WDOG   = 20000;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    miss_valid = 1'b0;
   logic [ADDR_W-1:0]       miss_addr = '0;
   logic                    miss_ready, busy, mem_req_valid;
   logic [ADDR_W-1:0]       mem_req_addr;
   logic                    mem_req_ready = 1'b0;
   logic                    mem_rsp_valid = 1'b0;
   logic [DATA_W-1:0]       mem_rsp_data = '0;
   logic                    restart_pulse, fill_done, line_valid;
   logic [DATA_W-1:0]       restart_data;
   logic [TAG_W-1:0]        line_tag;
   logic [WORDS*DATA_W-1:0] line_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   line_refill_seq dut_i (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .miss_ready(miss_ready), .busy(busy), .mem_req_valid(mem_req_valid),
      .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .restart_pulse(restart_pulse), .restart_data(restart_data),
      .fill_done(fill_done), .line_valid(line_valid), .line_tag(line_tag),
      .line_data(line_data)
   );

   int tests = 0;
   int fails = 0;
   int done_cnt = 0;
   int cyc = 0;
   bit finished = 1'b0;
   int mode = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return a ^ 32'hC0DE_0000 ^ (a << 7);
   endfunction

   // scoreboard state
   logic [31:0] exp_line_q[$];
   logic [31:0] exp_req_q[$];
   logic [31:0] pend_q[$];
   logic [31:0] cur_addr, first_addr, addr_prev;
   bit busy_prev = 1'b0, rsp_first_prev = 1'b0, rsp_last_prev = 1'b0, wait_prev = 1'b0;
   int req_seen = 0, rsp_sent = 0;
   logic [15:0] lfsr = 16'hACE1;

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (busy && !busy_prev) begin
            check(line_valid == 1'b0, "R8", "valid cleared on accept", line_valid, 0);
            if (exp_line_q.size() == 0) begin
               check(1'b0, "R6", "unexpected accept", busy, 0);
            end else begin
               cur_addr = exp_line_q.pop_front();
               exp_req_q.delete();
               for (int k = 0; k < WORDS; k++) begin
                  logic [2:0] o;
                  o = 3'(cur_addr[4:2] + k);
                  exp_req_q.push_back({cur_addr[31:5], o, 2'b00});
               end
               first_addr = {cur_addr[31:2], 2'b00};
               req_seen = 0;
               rsp_sent = 0;
            end
         end
         if (restart_pulse || rsp_first_prev) begin
            check(restart_pulse == rsp_first_prev, "R5", "restart timing", restart_pulse, rsp_first_prev);
            if (restart_pulse && rsp_first_prev)
               check(restart_data == mem_word(first_addr), "R5", "restart data",
                     restart_data, mem_word(first_addr));
         end
         if (fill_done || rsp_last_prev) begin
            check(fill_done == rsp_last_prev, "R7", "done timing", fill_done, rsp_last_prev);
            if (rsp_last_prev) begin
               check(busy == 1'b0, "R7", "busy low at done", busy, 0);
               check(line_valid == 1'b1, "R8", "line valid", line_valid, 1);
               check(line_tag == cur_addr[31:5], "R8", "line tag", line_tag, cur_addr[31:5]);
               check(req_seen == WORDS, "R3", "request count", req_seen, WORDS);
               for (int i = 0; i < WORDS; i++) begin
                  logic [31:0] ea;
                  ea = {cur_addr[31:5], 3'(i), 2'b00};
                  check(line_data[i*DATA_W +: DATA_W] == mem_word(ea), "R4", "line word",
                        line_data[i*DATA_W +: DATA_W], mem_word(ea));
               end
               done_cnt++;
            end
         end
         if (wait_prev)
            check(mem_req_valid && mem_req_addr == addr_prev, "R9", "stalled request held",
                  mem_req_addr, addr_prev);
         // memory response side
         rsp_first_prev = 1'b0;
         rsp_last_prev  = 1'b0;
         if (pend_q.size() > 0 && (mode == 0 || lfsr[3:2] != 2'b00)) begin
            logic [31:0] a;
            a = pend_q.pop_front();
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(a);
            if (rsp_sent == 0) rsp_first_prev = 1'b1;
            rsp_sent++;
            if (rsp_sent == WORDS) rsp_last_prev = 1'b1;
         end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hDEAD_BEEF;
         end
         // memory request side
         mem_req_ready = (mode == 0) || lfsr[0] || lfsr[5];
         if (mem_req_valid && mem_req_ready) begin
            if (exp_req_q.size() == 0) begin
               check(1'b0, "R3", "extra request", mem_req_addr, 0);
            end else begin
               logic [31:0] e;
               e = exp_req_q.pop_front();
               check(mem_req_addr == e, (req_seen == 0) ? "R2" : "R3", "request address",
                     mem_req_addr, e);
            end
            pend_q.push_back(mem_req_addr);
            req_seen++;
         end
         wait_prev = mem_req_valid && !mem_req_ready;
         addr_prev = mem_req_addr;
         busy_prev = busy;
      end
   end

   task automatic do_miss(input logic [31:0] a, input bit decoy);
      @(negedge clk);
      while (!miss_ready) @(negedge clk);
      exp_line_q.push_back(a);
      miss_valid = 1'b1;
      miss_addr  = a;
      @(negedge clk);
      if (decoy) begin
         miss_addr = a ^ 32'h0000_1F7C;   // R6: ignored while busy
         repeat (2) @(negedge clk);
      end
      miss_valid = 1'b0;
   endtask

   task automatic wait_done(input int n);
      while (done_cnt < n) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (cyc > WDOG && !finished) begin
         finished = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(busy == 1'b0, "R1", "busy", busy, 0);
      check(mem_req_valid == 1'b0, "R1", "req valid", mem_req_valid, 0);
      check(line_valid == 1'b0, "R1", "line valid", line_valid, 0);
      check(miss_ready == 1'b1, "R1", "miss ready", miss_ready, 1);
      check(!restart_pulse && !fill_done, "R1", "strobes", {restart_pulse, fill_done}, 0);
      mode = 0;
      do_miss(32'h0000_1000, 1'b0);   // offset 0, no wrap
      do_miss(32'h0000_203C, 1'b0);   // offset 7, starts right after accept-in-done
      do_miss(32'h1234_566C, 1'b1);   // offset 3, decoy while busy
      wait_done(3);
      mode = 1;
      do_miss(32'hFFFF_FFF4, 1'b0);   // offset 5, all-ones tag, stalls
      do_miss(32'h8000_0024, 1'b0);   // offset 1
      do_miss(32'h0ABC_DEF8, 1'b1);   // offset 6, decoy
      wait_done(6);
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && mem_req_valid == 1'b0, "R6", "idle after fills",
            {busy, mem_req_valid}, 0);
      check(done_cnt == 6, "R7", "fill count", done_cnt, 6);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule